// File: doc/BRIEF.md
# Transmit Frame Buffer Controller

This block keeps one outgoing frame for a serial vehicle-network data link and feeds it, byte by byte, to a bit-level transmitter. Software fills up to eleven header and data bytes through a small register port. It then writes a byte count, and that write launches the frame. The block presents each stored byte in address order on a valid/ready stream. After the last data byte it presents the check byte that an external CRC generator supplies. It then waits for the transmitter to report one of three outcomes.

A success report frees the buffer and sets a sticky done flag. That flag raises an interrupt request when interrupts are enabled. A bus error drops the frame with no status and no retry. A lost arbitration keeps the frame and sends it again from its first byte once the bus is idle. Software may abort at any time. The abort indication lasts one cycle and leaves the buffer empty.

Register map: addresses 0 to 10 are the byte slots, 11 is the count register, 12 is control (bit 0 abort, bit 1 interrupt enable), and 13 is status (bit 0 done, cleared by writing 1).

Top module: `txbuf_ctl`

## Requirements
- R1: After reset, busy, abort_active, tx_done, irq, tx_valid, tx_sof and tx_last are all 0.
- R2: While idle, a write to addresses 0 to 10 stores that byte. A write of a count from 1 to 11 to address 11 makes busy 1 from the next cycle, with tx_valid and tx_sof high and byte 0 presented.
- R3: Stored bytes are presented in address order, and one byte is consumed at each clock edge where tx_valid and tx_ready are both high. While tx_ready is low, tx_data and tx_valid hold.
- R4: Once the byte at index count-1 has been accepted, the next byte presented is crc_in with tx_last 1. After that byte is accepted, tx_valid stays 0 and busy stays 1 until an outcome arrives.
- R5: A link_ok pulse while waiting for the outcome sets tx_done and clears busy on the next cycle. irq equals tx_done AND the interrupt enable (control bit 1).
- R6: Writing a status value with bit 0 set clears tx_done, and with it irq. Writing 0 to status leaves tx_done unchanged.
- R7: A control write with bit 0 set makes abort_active 1 for exactly one cycle. busy then reads 0 and tx_valid reads 0, and tx_done is not changed.
- R8: A link_err pulse during a frame drops it. On the next cycle busy and tx_valid are 0, tx_done is unchanged, and a new frame may be loaded.
- R9: A link_lost pulse during a frame stops presentation on the next cycle while busy stays 1. In the cycle after bus_idle is seen high, the frame restarts from byte 0 with tx_sof high.
- R10: While busy, writes to addresses 0 to 11 are ignored: the bytes and the count of the frame in progress do not change.
- R11: A count write of 0, or of any value above 11, while idle does not start a frame, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Register write data |
| busy | output | 1 | Buffer holds a frame or an abort is in progress |
| abort_active | output | 1 | Abort in progress; clears itself |
| tx_done | output | 1 | Sticky successful-transmission flag |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | A byte is presented to the transmitter |
| tx_ready | input | 1 | Transmitter takes the presented byte |
| tx_data | output | 8 | Presented byte |
| tx_sof | output | 1 | Presented byte is the first of the frame |
| tx_last | output | 1 | Presented byte is the check byte |
| crc_in | input | 8 | Check byte from the external CRC generator |
| link_ok | input | 1 | Frame completed on the bus (pulse) |
| link_err | input | 1 | Bus error seen (pulse) |
| link_nil | input | 1 | Unused spare strobe, tie to 0 |
| link_lost | input | 1 | Arbitration lost (pulse) |
| bus_idle | input | 1 | Bus idle condition |

## Verification
Every result is registered, so a register write, a handshake or an outcome pulse sampled at one rising edge shows on the outputs during the cycle that follows. irq follows tx_done in that same cycle. The bench drives inputs 1 ns after a rising edge and holds each strobe for exactly one edge. It reads the outputs after that edge has settled and before the next one. This applies the expected one-cycle latency to start, byte advance, check-byte switch, done, abort, drop and restart alike. Stall cycles are inserted before chosen bytes to show that the presented byte holds.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY, ST_DATA, ST_CRC, ST_WAIT, ST_HOLD, ST_ABORT
  } txbuf_state_e;

  // A count launches a frame only if it is 1..depth.
  function automatic logic count_usable(input int unsigned cnt, input int unsigned depth);
    return (cnt != 0) && (cnt <= depth);
  endfunction

  // True when idx is the last data index of a cnt-byte frame.
  function automatic logic is_final(input int unsigned idx, input int unsigned cnt);
    return (idx + 1) == cnt;
  endfunction

endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int DEPTH = 11,
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (wr_en && wr_addr == AW'(g))     mem[g] <= wr_data;
    end
  end

  assign rd_data = (rd_idx < IW'(DEPTH)) ? mem[rd_idx] : '0;
endmodule

// File: rtl/txbuf_seq.sv
module txbuf_seq
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 11,
  parameter int IW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] start_cnt,
  input  logic          abort_req,
  input  logic          tx_ready,
  input  logic          link_ok,
  input  logic          link_err,
  input  logic          link_lost,
  input  logic          bus_idle,
  output txbuf_state_e  st,
  output logic [IW-1:0] idx,
  output logic          evt_ok,
  output logic          evt_drop,
  output logic          evt_lost
);
  txbuf_state_e  st_n;
  logic [IW-1:0] idx_n;
  logic [IW-1:0] cnt_q;
  logic          sending;

  assign sending = (st == ST_DATA) || (st == ST_CRC) || (st == ST_WAIT);

  always_comb begin
    st_n     = st;
    idx_n    = idx;
    evt_ok   = 1'b0;
    evt_drop = 1'b0;
    evt_lost = 1'b0;
    if (abort_req) begin
      st_n  = ST_ABORT;
      idx_n = '0;
    end else if (sending) begin
      if (link_err) begin
        st_n = ST_EMPTY;  evt_drop = 1'b1;
      end else if (link_lost) begin
        st_n = ST_HOLD;   idx_n = '0;  evt_lost = 1'b1;
      end else if (st == ST_DATA && tx_ready) begin
        if (is_final(32'(idx), 32'(cnt_q))) st_n = ST_CRC;
        else                                idx_n = idx + 1'b1;
      end else if (st == ST_CRC && tx_ready) begin
        st_n = ST_WAIT;
      end else if (st == ST_WAIT && link_ok) begin
        st_n = ST_EMPTY;  evt_ok = 1'b1;
      end
    end else begin
      case (st)
        ST_EMPTY: if (start) begin st_n = ST_DATA; idx_n = '0; end
        ST_HOLD:  if (bus_idle) st_n = ST_DATA;
        default:  st_n = ST_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_EMPTY;
      idx   <= '0;
      cnt_q <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      if (st == ST_EMPTY && start && !abort_req) cnt_q <= start_cnt;
    end
  end

  localparam int unsigned DEPTH_U = DEPTH;
  logic unused_depth;
  assign unused_depth = (DEPTH_U == 0);
endmodule

// File: rtl/txbuf_flags.sv
module txbuf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic clr_done,
  input  logic ctl_wr,
  input  logic ie_in,
  output logic done,
  output logic ie,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (set_done)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (ctl_wr)        ie   <= ie_in;
    end
  end

  assign irq = done & ie;
endmodule

// File: rtl/txbuf_ctl.sv
module txbuf_ctl
  import txbuf_pkg::*;
#(
  parameter  int DEPTH = 11,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          busy,
  output logic          abort_active,
  output logic          tx_done,
  output logic          irq,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_sof,
  output logic          tx_last,
  input  logic [DW-1:0] crc_in,
  input  logic          link_ok,
  input  logic          link_err,
  input  logic          link_nil,
  input  logic          link_lost,
  input  logic          bus_idle
);
  localparam int IW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_CNT = AW'(DEPTH);
  localparam logic [AW-1:0] A_CTL = AW'(DEPTH + 1);
  localparam logic [AW-1:0] A_STS = AW'(DEPTH + 2);

  txbuf_state_e  st;
  logic [IW-1:0] idx;
  logic [DW-1:0] rd_data;
  logic          ie;

  // Named internal events
  logic wr_store, wr_start, abort_req, ctl_wr, clr_done;
  logic evt_ok, evt_drop, evt_lost;

  assign busy      = (st != ST_EMPTY);
  assign wr_store  = cpu_we && !busy && (cpu_addr < A_CNT);
  assign wr_start  = cpu_we && !busy && (cpu_addr == A_CNT)
                     && count_usable(32'(cpu_wdata), DEPTH);
  assign ctl_wr    = cpu_we && (cpu_addr == A_CTL);
  assign abort_req = ctl_wr && cpu_wdata[0];
  assign clr_done  = cpu_we && (cpu_addr == A_STS) && cpu_wdata[0];

  txbuf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_store), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .rd_idx(idx), .rd_data(rd_data)
  );

  txbuf_seq #(.DEPTH(DEPTH), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .start_cnt(IW'(cpu_wdata)),
    .abort_req(abort_req), .tx_ready(tx_ready), .link_ok(link_ok),
    .link_err(link_err), .link_lost(link_lost), .bus_idle(bus_idle),
    .st(st), .idx(idx), .evt_ok(evt_ok), .evt_drop(evt_drop), .evt_lost(evt_lost)
  );

  txbuf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_done(evt_ok), .clr_done(clr_done),
    .ctl_wr(ctl_wr), .ie_in(cpu_wdata[1]), .done(tx_done), .ie(ie), .irq(irq)
  );

  assign abort_active = (st == ST_ABORT);
  assign tx_valid     = (st == ST_DATA) || (st == ST_CRC);
  assign tx_last      = (st == ST_CRC);
  assign tx_sof       = (st == ST_DATA) && (idx == '0);
  assign tx_data      = tx_last ? crc_in : (tx_valid ? rd_data : '0);

  logic unused_ok;
  assign unused_ok = evt_drop | evt_lost | link_nil;
endmodule

// File: rtl/txbuf_chk.sv
module txbuf_chk #(
  parameter  int DEPTH = 11,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH + 3)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic          busy,
  input logic          abort_active,
  input logic          tx_done,
  input logic          irq,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_sof,
  input logic          tx_last,
  input logic          link_ok,
  input logic          link_err,
  input logic          link_lost,
  input logic          evt_ok
);
  logic abort_wr, bad_cnt_wr;
  assign abort_wr   = cpu_we && cpu_addr == AW'(DEPTH + 1) && cpu_wdata[0];
  assign bad_cnt_wr = cpu_we && cpu_addr == AW'(DEPTH)
                      && (cpu_wdata == '0 || cpu_wdata > DW'(DEPTH));

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !tx_done); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_last && !link_err && !link_lost && !abort_wr)
    |=> tx_valid && $stable(tx_data)); // R3
  AST_CRC_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !link_err && !link_lost && !abort_wr)
    |=> !tx_valid && busy && !tx_sof); // R4
  AST_OK_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ok |=> tx_done && !busy); // R5
  AST_DONE_FROM_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(link_ok)); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_done); // R5
  AST_ABORT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_active && !abort_wr) |=> !abort_active && !busy); // R7
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && link_err && !abort_wr) |=> !busy && !tx_valid); // R8
  AST_LOST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && link_lost && !link_err && !abort_wr) |=> busy && !tx_valid); // R9
  AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bad_cnt_wr) |=> !busy); // R11
endmodule

bind txbuf_ctl txbuf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .busy(busy), .abort_active(abort_active),
  .tx_done(tx_done), .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_sof(tx_sof), .tx_last(tx_last), .link_ok(link_ok),
  .link_err(link_err), .link_lost(link_lost), .evt_ok(evt_ok)
);

// File: tb/txbuf_ctl_tb_top.sv
`timescale 1ns/1ps
module txbuf_ctl_tb_top;
  localparam int A_CNT = 11, A_CTL = 12, A_STS = 13;

  typedef struct packed {
    logic [3:0] cnt;
    logic [7:0] seed;
    logic [7:0] crc;
    logic [7:0] stall;
    logic       ie;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{4'd1,  8'h10, 8'h5A, 8'b0000_0000, 1'b1},
    '{4'd5,  8'hA0, 8'h3C, 8'b0001_0101, 1'b0},
    '{4'd11, 8'h01, 8'hE7, 8'b1010_0110, 1'b1},
    '{4'd3,  8'hF0, 8'h81, 8'b0000_1000, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, crc_in = '0;
  logic tx_ready = 1'b0, link_ok = 1'b0, link_err = 1'b0, link_lost = 1'b0, bus_idle = 1'b0;
  logic busy, abort_active, tx_done, irq, tx_valid, tx_sof, tx_last;
  logic [7:0] tx_data;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  txbuf_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .busy(busy), .abort_active(abort_active), .tx_done(tx_done), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_last(tx_last), .crc_in(crc_in), .link_ok(link_ok), .link_err(link_err),
    .link_nil(1'b0), .link_lost(link_lost), .bus_idle(bus_idle)
  );

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input int addr, input logic [7:0] data);
    cpu_we = 1'b1; cpu_addr = 4'(addr); cpu_wdata = data;
    step();
    cpu_we = 1'b0;
  endtask

  task automatic load_start(input int cnt, input logic [7:0] seed);
    for (int i = 0; i < cnt; i++) cpu_wr(i, pay(seed, i));
    cpu_wr(A_CNT, 8'(cnt));
    chk("R2 busy after start", busy, 1);
    chk("R2 sof after start", {tx_valid, tx_sof}, 2'b11);
  endtask

  task automatic pulse_ok();
    link_ok = 1'b1; step(); link_ok = 1'b0;
  endtask

  // Streams bytes first..cnt (cnt = check byte) with optional stall cycles.
  task automatic stream(input int first, input int cnt, input logic [7:0] seed,
                        input logic [7:0] crc, input logic [7:0] stall);
    crc_in = crc;
    for (int k = first; k <= cnt; k++) begin
      logic [7:0] e;
      e = (k == cnt) ? crc : pay(seed, k);
      if (stall[k % 8]) begin
        tx_ready = 1'b0; step();
        chk("R3 hold while stalled", {tx_valid, tx_data}, {1'b1, e});
      end
      chk(k == cnt ? "R4 check byte" : "R3 data byte", tx_data, e);
      chk("R4 last flag", tx_last, (k == cnt));
      chk("R3 sof flag", tx_sof, (k == 0));
      tx_ready = 1'b1; step(); tx_ready = 1'b0;
    end
    chk("R4 wait for outcome", {busy, tx_valid, tx_done}, 3'b100);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 reset outputs", {busy, abort_active, tx_done, irq, tx_valid, tx_sof, tx_last}, 7'b0);
    rst_n = 1'b1; step();

    // Table-driven frames
    foreach (VECS[v]) begin
      cpu_wr(A_CTL, {6'b0, VECS[v].ie, 1'b0});
      load_start(int'(VECS[v].cnt), VECS[v].seed);
      stream(0, int'(VECS[v].cnt), VECS[v].seed, VECS[v].crc, VECS[v].stall);
      pulse_ok();
      chk("R5 done and free", {tx_done, busy}, 2'b10);
      chk("R5 irq gating", irq, VECS[v].ie);
      cpu_wr(A_STS, 8'h01);
      chk("R6 clear done", {tx_done, irq}, 2'b00);
    end

    // R11 invalid counts
    cpu_wr(A_CNT, 8'd0);  chk("R11 count 0", busy, 0);
    cpu_wr(A_CNT, 8'd12); chk("R11 count 12", busy, 0);
    cpu_wr(A_CNT, 8'hFF); chk("R11 count 255", {busy, tx_valid}, 2'b00);

    // R6 write 0 does nothing; done stays set
    cpu_wr(A_CTL, 8'h02);
    load_start(2, 8'h44);
    stream(0, 2, 8'h44, 8'h99, 8'h00);
    pulse_ok();
    cpu_wr(A_STS, 8'h00);
    chk("R6 write 0 keeps done", {tx_done, irq}, 2'b11);

    // R7 abort mid-frame, done unaffected
    load_start(4, 8'h20);
    tx_ready = 1'b1; step(); tx_ready = 1'b0;
    cpu_wr(A_CTL, 8'h01);
    chk("R7 abort indicated", {abort_active, busy}, 2'b11);
    step();
    chk("R7 abort self-clears", {abort_active, busy, tx_valid}, 3'b000);
    chk("R7 done untouched", tx_done, 1);
    cpu_wr(A_STS, 8'h01);

    // R8 bus error drops frame silently
    load_start(3, 8'h60);
    tx_ready = 1'b1; step(); step(); tx_ready = 1'b0;
    link_err = 1'b1; step(); link_err = 1'b0;
    chk("R8 dropped", {busy, tx_valid, tx_done}, 3'b000);
    load_start(1, 8'h77);
    stream(0, 1, 8'h77, 8'h12, 8'h00);
    pulse_ok();
    chk("R8 buffer reusable", {tx_done, busy}, 2'b10);
    cpu_wr(A_STS, 8'h01);

    // R10 writes while busy ignored; R9 lost arbitration retry
    load_start(3, 8'h30);
    tx_ready = 1'b1; step(); tx_ready = 1'b0;
    cpu_wr(0, 8'hEE);
    cpu_wr(A_CNT, 8'd5);
    chk("R10 still presenting byte 1", tx_data, pay(8'h30, 1));
    link_lost = 1'b1; step(); link_lost = 1'b0;
    chk("R9 stopped, kept", {busy, tx_valid}, 2'b10);
    step();
    chk("R9 waits for idle", {busy, tx_valid}, 2'b10);
    bus_idle = 1'b1; step(); bus_idle = 1'b0;
    chk("R9 restart sof", {tx_valid, tx_sof}, 2'b11);
    chk("R10 byte 0 unchanged", tx_data, pay(8'h30, 0));
    stream(0, 3, 8'h30, 8'h6B, 8'h02);
    pulse_ok();
    chk("R10 count unchanged, R9 done", {tx_done, busy}, 2'b10);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule